// File: doc/BRIEF.md
# Gated High/Low Phase Clock Divider Bank

This block derives several slower clock waveforms from one parent clock. Each channel produces a level output and a one-cycle tick. The level output is high during the high phase of the derived clock. The tick marks the first parent cycle of each derived period. Downstream logic can use the level as a divided clock, or use the tick as a clock enable. Each channel is steered by its own divider word and by a gate bit. Both are written and read back over a simple single-cycle register port.

The divider word holds a mode bit and two independent count fields. With the mode bit clear, the channel runs at the parent rate. The level output stays high and a tick is issued on every parent cycle. With the mode bit set, the level output is high for one more cycle than the high field and low for one more cycle than the low field. The output period is therefore the sum of the two field values plus two.

New divider words are picked up only where a derived period ends, so no runt pulse appears. Clearing a gate lets the phase in progress finish, then parks the output low. Setting the gate again restarts the output at the beginning of a high phase. Channels marked gateless at build time ignore gate writes and always run.

Top module: `clkdiv_bank`

## Requirements
- R1: The reset input clears all divider words and gate bits asynchronously, and drives every level and tick output low at once.
- R2: With divider word bit 0 clear on a running channel, the level output is high and the tick output is high on every parent cycle.
- R3: With divider word bit 0 set, the level output is high for H+1 parent cycles and then low for L+1 cycles, where H is word bits 4:1 and L is word bits 8:5. The tick output is high only on the first cycle of each high phase.
- R4: With bit 0 set and both count fields zero, the level output toggles on every parent cycle, which gives division by two at 50 % duty.
- R5: A divider word written mid-period takes effect only at the start of the next derived period. That is the end of a low phase in divided mode, or the next cycle in pass-through mode. The phases already under way keep their old lengths.
- R6: Gate register bit 0 runs a gated channel. When it is cleared, the current high or low phase completes, then the level and tick outputs stay low. When it is set, the channel starts a new period with a high phase, two cycles after the write cycle.
- R7: Channels whose bit is clear in the build-time gate mask always run. Gate writes to them have no effect, and their gate register reads back as 1.
- R8: Reading returns the last divider word of the selected channel (rd_gate low) or its gate state in bit 0 (rd_gate high). Writes to a channel number of NCH or above change nothing, and reads of such a number return 0.
- R9: The internal reset is released on the third rising clock edge after rst_n rises. Register writes and channel progress start at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_gate | input | 1 | Write target: 1 gate register, 0 divider word |
| wr_ch | input | CH_W | Channel number for the write |
| wr_data | input | DIV_W | Write data |
| rd_gate | input | 1 | Read target: 1 gate register, 0 divider word |
| rd_ch | input | CH_W | Channel number for the read |
| rd_data | output | DIV_W | Combinational read data |
| ch_level | output | NCH | Derived clock level per channel |
| ch_tick | output | NCH | Period-start pulse per channel |

## Verification
The bench rewrites the divider word at many offsets inside high and low phases. A design that loaded new counts straight away would show a stretched or clipped phase right after the write. It clears and re-sets the gate at every offset within a period, to catch a design that cuts a high phase short or resumes in the middle of a low phase. It also drives the one-cycle high and low case, the pass-through mode, gate writes to the gateless channel and accesses to a channel number out of range. Each of these corner cases has its own failure signature: a toggling output stuck high, a missing tick, a gateless channel that stops, or stray read data.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // Channel phase encoding
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2,
    PH_BYP  = 2'd3
  } phase_e;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
  parameter int NCH = 3,
  parameter int CH_W = 2,
  parameter int DIV_W = 9,
  parameter logic [NCH-1:0] GATE_MASK = '1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            wr_gate,
  input  logic [CH_W-1:0]                 wr_ch,
  input  logic [DIV_W-1:0]                wr_data,
  input  logic                            rd_gate,
  input  logic [CH_W-1:0]                 rd_ch,
  output logic [DIV_W-1:0]                rd_data,
  output logic [NCH-1:0][DIV_W-1:0]       div_cfg,
  output logic [NCH-1:0]                  run
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic             hit;
    logic             div_ld;
    logic [DIV_W-1:0] div_q;

    assign hit    = wr_en && (wr_ch == CH_W'(i));
    assign div_ld = hit && !wr_gate;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (div_ld) div_q <= wr_data;
    end
    assign div_cfg[i] = div_q;

    if (GATE_MASK[i]) begin : g_gate
      logic gate_ld;
      logic gate_q;
      assign gate_ld = hit && wr_gate;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gate_q <= 1'b0;
        else if (gate_ld) gate_q <= wr_data[0];
      end
      assign run[i] = gate_q;
    end else begin : g_nogate
      assign run[i] = 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCH; i++) begin
      if (rd_ch == CH_W'(i)) begin
        rd_data = rd_gate ? DIV_W'(run[i]) : div_cfg[i];
      end
    end
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
  import clkdiv_pkg::*;
#(
  parameter int DIV_W = 9,
  parameter int EN_POS = 0,
  parameter int HI_LSB = 1,
  parameter int HI_W = 4,
  parameter int LO_LSB = 5,
  parameter int LO_W = 4,
  localparam int CNT_W = (HI_W > LO_W) ? HI_W : LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg,
  input  logic             run,
  output logic             level,
  output logic             tick
);
  phase_e             state_q, state_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CNT_W-1:0]   lo_q, lo_d;
  logic               level_q, level_d;
  logic               tick_q, tick_d;
  logic               start;
  logic               cfg_en;
  logic [HI_W-1:0]    cfg_hi;
  logic [LO_W-1:0]    cfg_lo;

  assign cfg_en = cfg[EN_POS];
  assign cfg_hi = cfg[HI_LSB +: HI_W];
  assign cfg_lo = cfg[LO_LSB +: LO_W];

  // Next-state: phases count down; a new period samples cfg
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lo_d    = lo_q;
    tick_d  = 1'b0;
    start   = 1'b0;
    unique case (state_q)
      PH_IDLE: start = run;
      PH_HIGH: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (run) begin
          state_d = PH_LOW;
          cnt_d   = lo_q;
        end else state_d = PH_IDLE;
      end
      PH_LOW: begin
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (run)    start = 1'b1;
        else             state_d = PH_IDLE;
      end
      PH_BYP: begin
        if (run) start = 1'b1;
        else     state_d = PH_IDLE;
      end
      default: state_d = PH_IDLE;
    endcase
    if (start) begin
      tick_d = 1'b1;
      if (cfg_en) begin
        state_d = PH_HIGH;
        cnt_d   = CNT_W'(cfg_hi);
        lo_d    = CNT_W'(cfg_lo);
      end else begin
        state_d = PH_BYP;
      end
    end
    level_d = (state_d == PH_HIGH) || (state_d == PH_BYP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      lo_q    <= '0;
      level_q <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lo_q    <= lo_d;
      level_q <= level_d;
      tick_q  <= tick_d;
    end
  end

  assign level = level_q;
  assign tick  = tick_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NCH = 3,
  parameter int EN_POS = 0,
  parameter int HI_LSB = 1,
  parameter int HI_W = 4,
  parameter int LO_LSB = 5,
  parameter int LO_W = 4,
  parameter logic [NCH-1:0] GATE_MASK = 3'b011,
  localparam int TOP_A = (EN_POS + 1 > HI_LSB + HI_W) ? EN_POS + 1 : HI_LSB + HI_W,
  localparam int DIV_W = (TOP_A > LO_LSB + LO_W) ? TOP_A : LO_LSB + LO_W,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_gate,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             rd_gate,
  input  logic [CH_W-1:0]  rd_ch,
  output logic [DIV_W-1:0] rd_data,
  output logic [NCH-1:0]   ch_level,
  output logic [NCH-1:0]   ch_tick
);
  logic                      rst_i_n;
  logic [NCH-1:0][DIV_W-1:0] div_cfg;
  logic [NCH-1:0]            run_w;

  clkdiv_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_i_n)
  );

  clkdiv_regs #(
    .NCH       (NCH),
    .CH_W      (CH_W),
    .DIV_W     (DIV_W),
    .GATE_MASK (GATE_MASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (wr_en),
    .wr_gate (wr_gate),
    .wr_ch   (wr_ch),
    .wr_data (wr_data),
    .rd_gate (rd_gate),
    .rd_ch   (rd_ch),
    .rd_data (rd_data),
    .div_cfg (div_cfg),
    .run     (run_w)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    clkdiv_chan #(
      .DIV_W  (DIV_W),
      .EN_POS (EN_POS),
      .HI_LSB (HI_LSB),
      .HI_W   (HI_W),
      .LO_LSB (LO_LSB),
      .LO_W   (LO_W)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_i_n),
      .cfg   (div_cfg[i]),
      .run   (run_w[i]),
      .level (ch_level[i]),
      .tick  (ch_tick[i])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NCH = 3,
  parameter int CH_W = 2,
  parameter int DIV_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   ch_level,
  input logic [NCH-1:0]   ch_tick,
  input logic [NCH-1:0]   run,
  input logic [CH_W-1:0]  rd_ch,
  input logic [DIV_W-1:0] rd_data
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    p_tick_in_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> ch_level[i]);
    p_rise_has_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_level[i]) |-> ch_tick[i]);
    p_high_continues_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_level[i] && !ch_tick[i]) |-> $past(ch_level[i]));
    p_parked_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !ch_level[i]) |=> !ch_level[i]);
  end

  p_bad_ch_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_ch) >= NCH) |-> (rd_data == '0));
endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .NCH   (NCH),
  .CH_W  (CH_W),
  .DIV_W (DIV_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_level (ch_level),
  .ch_tick  (ch_tick),
  .run      (run_w),
  .rd_ch    (rd_ch),
  .rd_data  (rd_data)
);

// File: tb/sim_clkdiv_bank.sv
`timescale 1ns/1ps
module sim_clkdiv_bank;
  localparam int NCH = 3;
  localparam int DIV_W = 9;
  localparam int CH_W = 2;
  localparam logic [NCH-1:0] GMASK = 3'b011;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_en;
  logic             wr_gate;
  logic [CH_W-1:0]  wr_ch;
  logic [DIV_W-1:0] wr_data;
  logic             rd_gate;
  logic [CH_W-1:0]  rd_ch;
  logic [DIV_W-1:0] rd_data;
  logic [NCH-1:0]   ch_level;
  logic [NCH-1:0]   ch_tick;

  always #10 clk = ~clk; // 50 MHz

  clkdiv_bank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_gate(wr_gate),
    .wr_ch(wr_ch), .wr_data(wr_data), .rd_gate(rd_gate), .rd_ch(rd_ch),
    .rd_data(rd_data), .ch_level(ch_level), .ch_tick(ch_tick)
  );

  // Reference model
  int    m_div[NCH];
  int    m_gate[NCH];
  int    m_ph[NCH];     // 0 parked, 1 high, 2 low, 3 pass-through
  int    m_left[NCH];   // cycles remaining in phase, this one included
  int    m_lo[NCH];
  bit    m_tick[NCH];
  int    edges_up;
  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string req = "R1";

  function automatic int mk(int en, int hi, int lo);
    return en | (hi << 1) | (lo << 5);
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_div[c] = 0; m_gate[c] = 0; m_ph[c] = 0; m_left[c] = 0;
      m_lo[c] = 0; m_tick[c] = 0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < NCH; c++) begin
      bit go;
      bit runs;
      runs = GMASK[c] ? (m_gate[c] != 0) : 1'b1;
      go = 0;
      m_tick[c] = 0;
      case (m_ph[c])
        0: go = runs;
        1: if (m_left[c] > 1) m_left[c]--;
           else if (runs) begin m_ph[c] = 2; m_left[c] = m_lo[c] + 1; end
           else m_ph[c] = 0;
        2: if (m_left[c] > 1) m_left[c]--;
           else if (runs) go = 1;
           else m_ph[c] = 0;
        default: if (runs) go = 1; else m_ph[c] = 0;
      endcase
      if (go) begin
        m_tick[c] = 1;
        if (m_div[c] & 1) begin
          m_ph[c] = 1;
          m_left[c] = ((m_div[c] >> 1) & 15) + 1;
          m_lo[c] = (m_div[c] >> 5) & 15;
        end else m_ph[c] = 3;
      end
    end
    if (wr_en && int'(wr_ch) < NCH) begin
      if (wr_gate) begin
        if (GMASK[wr_ch]) m_gate[wr_ch] = int'(wr_data[0]);
      end else m_div[wr_ch] = int'(wr_data);
    end
  endtask

  always @(negedge rst_n) model_reset();

  always @(posedge clk) begin
    if (!rst_n) begin
      model_reset();
      edges_up = 0;
    end else begin
      if (edges_up >= 2) model_step();
      edges_up++;
    end
  end

  // Compare against model away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic [NCH-1:0]   el, et;
      logic [DIV_W-1:0] er;
      for (int c = 0; c < NCH; c++) begin
        el[c] = (m_ph[c] == 1) || (m_ph[c] == 3);
        et[c] = m_tick[c];
      end
      if (int'(rd_ch) >= NCH) er = '0;
      else if (rd_gate) er = GMASK[rd_ch] ? DIV_W'(m_gate[rd_ch]) : DIV_W'(1);
      else er = DIV_W'(m_div[rd_ch]);
      checks++;
      if (ch_level !== el || ch_tick !== et || rd_data !== er) begin
        fails++;
        $display("FAIL %s t=%0t level=%b tick=%b rd=%h expected level=%b tick=%b rd=%h",
                 req, $time, ch_level, ch_tick, rd_data, el, et, er);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(bit g, int ch, int data);
    @(posedge clk); #2;
    wr_en = 1; wr_gate = g; wr_ch = CH_W'(ch); wr_data = DIV_W'(data);
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic rd(bit g, int ch);
    @(posedge clk); #2;
    rd_gate = g; rd_ch = CH_W'(ch);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_gate = 0; wr_ch = '0; wr_data = '0;
    rd_gate = 0; rd_ch = '0;
    req = "R1";
    idle(4);
    req = "R9";
    rst_n = 1;
    idle(8);

    req = "R2";  // pass-through on a gated channel
    wr(1, 0, 1);
    idle(8);

    req = "R3";  // H=2 L=4 on ch0, H=5 L=0 on ch1
    wr(0, 0, mk(1, 2, 4));
    wr(0, 1, mk(1, 5, 0));
    wr(1, 1, 1);
    idle(40);
    wr(0, 0, mk(1, 15, 15));
    idle(70);

    req = "R4";
    wr(0, 1, mk(1, 0, 0));
    wr(0, 0, mk(1, 0, 0));
    idle(20);

    req = "R5";  // rewrites at every offset in a period
    for (int k = 0; k < 12; k++) begin
      wr(0, 0, mk(1, 3, 2));
      idle(k);
      wr(0, 0, mk(1, 1, 5));
      idle(k + 3);
      wr(0, 1, (k % 2) ? mk(1, 2, 1) : 0);
      idle(2);
    end
    idle(20);

    req = "R6";  // gate clear and set at each offset
    wr(0, 0, mk(1, 3, 3));
    wr(0, 1, mk(1, 2, 0));
    for (int k = 0; k < 10; k++) begin
      idle(k);
      wr(1, 0, 0);
      wr(1, 1, 0);
      idle(k % 4);
      wr(1, 0, 1);
      idle(k % 3);
      wr(1, 1, 1);
    end
    wr(0, 1, 0);
    wr(1, 1, 0);
    idle(6);
    wr(1, 1, 1);
    idle(6);

    req = "R7";  // gateless channel ignores gate writes
    wr(1, 2, 0);
    idle(6);
    wr(0, 2, mk(1, 3, 1));
    wr(1, 2, 0);
    idle(20);
    rd(1, 2);
    idle(3);

    req = "R8";
    wr(0, 3, 9'h1ff);
    wr(1, 3, 1);
    for (int c = 0; c < 4; c++) begin
      rd(0, c); idle(1);
      rd(1, c); idle(1);
    end
    wr(0, 0, 9'h155);
    rd(0, 0); idle(2);
    rd(0, 3); idle(2);

    req = "R1";  // asynchronous reset mid-run
    @(posedge clk); #5;
    rst_n = 0;
    #1;
    checks++;
    if (ch_level !== '0 || ch_tick !== '0) begin
      fails++;
      $display("FAIL R1 async clear level=%b tick=%b expected level=000 tick=000",
               ch_level, ch_tick);
    end
    idle(3);
    req = "R9";
    rst_n = 1;
    idle(10);
    finish_run();
  end
endmodule